// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block turns a 32-bit virtual address into a 32-bit physical address by looking up its 20-bit virtual page number in a small table of page-to-frame mappings. Every entry is compared at once, so a mapping may sit in any slot. The 12-bit offset within the 4 KB page is not translated. On a hit, the result is the stored 20-bit frame number with the offset appended below it.

A lookup is presented for one cycle, and its response appears on the following cycle. If no valid entry matches, the block raises a fault flag and returns no address. External refill logic, usually software-driven, must then install the missing mapping. Refill uses a separate write port. Each write goes into the slot named by a round-robin pointer, which then advances. No table walk is done in hardware.

Top module: `xlate_buf`

## Requirements
- R1: After reset, every entry is invalid, `respValid` is 0, and any lookup reports a fault.
- R2: `respValid` is 1 in the cycle that follows a cycle with `lookupEn` high. It is 0 in the cycle that follows a cycle with `lookupEn` low.
- R3: On a hit, `respFault` is 0 and `respPa` equals `{frame[19:0], lookupVa[11:0]}`, with the frame number in bits 31:12.
- R4: On a miss, `respFault` is 1 and `respPa` is all zeros.
- R5: A refill writes the slot selected by a pointer. The pointer starts at 0 after reset, rises by one on each refill, and returns to 0 after slot ENTRIES-1. As a result, refill number ENTRIES+1 overwrites slot 0.
- R6: If several valid entries hold the same page number, the entry with the lowest index supplies the frame.
- R7: A lookup in the same cycle as a refill sees the table as it was before that refill.
- R8: In a cycle that follows no lookup, `respFault` is 0 and `respPa` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupEn | input | 1 | Request a translation of `lookupVa` |
| lookupVa | input | 32 | Virtual address to translate |
| fillEn | input | 1 | Install one entry at the round-robin slot |
| fillVpn | input | 20 | Virtual page number of the entry being installed |
| fillPfn | input | 20 | Frame number of the entry being installed |
| respValid | output | 1 | A response is present this cycle |
| respFault | output | 1 | The lookup missed; refill is required |
| respPa | output | 32 | Translated physical address; zero when there is no hit |

## Verification
The assertions take three things for granted: a reset pulse is applied before the first lookup, the inputs settle between clock edges, and the entry count is at least two so the slot pointer has a real wrap point. The bench changes inputs only on the falling edge and asserts reset at the start. Its stimulus deliberately covers repeated page numbers, a lookup in the same cycle as a refill of the same page, and a full lap of the replacement pointer. These cases expose the priority, ordering and wrap behaviour that the properties guard.

// File: rtl/xlate_pkg.sv
`timescale 1ns/1ps
package xlate_pkg;
  localparam int ADDR_W = 32;
  localparam int OFFS_W = 12;
  localparam int PAGE_W = ADDR_W - OFFS_W;

  typedef struct packed {
    logic fillWr;
    logic lookupCap;
  } xlateStrb_t;
endpackage

// File: rtl/xlate_ctrl.sv
`timescale 1ns/1ps
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupEn,
  input  logic             fillEn,
  output xlateStrb_t       strb,
  output logic [IDX_W-1:0] wrIdx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rrPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (fillEn) begin
      if (rrPtr == LAST_IDX) rrPtr <= '0;
      else                   rrPtr <= rrPtr + 1'b1;
    end
  end

  always_comb begin
    strb.fillWr    = fillEn;
    strb.lookupCap = lookupEn;
    wrIdx          = rrPtr;
  end

  // R5: pointer returns to slot 0 after the last slot is filled
  p_ptr_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fillEn && rrPtr == LAST_IDX) |=> (rrPtr == '0));
  // R5: pointer holds when no refill occurs
  p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !fillEn |=> $stable(rrPtr));
endmodule

// File: rtl/xlate_dpath.sv
`timescale 1ns/1ps
module xlate_dpath
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlateStrb_t        strb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [PAGE_W-1:0] fillVpn,
  input  logic [PAGE_W-1:0] fillPfn,
  input  logic [ADDR_W-1:0] lookupVa,
  output logic              respValid,
  output logic              respFault,
  output logic [ADDR_W-1:0] respPa
);
  logic [ENTRIES-1:0] validQ;
  logic [PAGE_W-1:0]  vpnQ [ENTRIES];
  logic [PAGE_W-1:0]  pfnQ [ENTRIES];
  logic [ENTRIES-1:0] matchVec;
  logic [ENTRIES-1:0] grantVec;
  logic [IDX_W-1:0]   hitIdx;
  logic               hitFound;
  logic [PAGE_W-1:0]  lookupVpn;

  assign lookupVpn = lookupVa[ADDR_W-1:OFFS_W];

  // valid bits: cleared by reset, set by refill
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            validQ <= '0;
    else if (strb.fillWr) validQ[wrIdx] <= 1'b1;
  end

  // tag and frame storage, no reset needed
  always_ff @(posedge clk) begin
    if (strb.fillWr) begin
      vpnQ[wrIdx] <= fillVpn;
      pfnQ[wrIdx] <= fillPfn;
    end
  end

  // parallel compare of every entry
  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
    assign matchVec[gi] = validQ[gi] && (vpnQ[gi] == lookupVpn);
  end

  // lowest index wins
  always_comb begin
    hitFound = 1'b0;
    hitIdx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        hitFound = 1'b1;
        hitIdx   = IDX_W'(i);
      end
    end
  end

  // independent one-hot form of the lowest match, used only for checking
  assign grantVec = matchVec & (~matchVec + 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respFault <= 1'b0;
      respPa    <= '0;
    end else begin
      respValid <= strb.lookupCap;
      if (strb.lookupCap) begin
        respFault <= !hitFound;
        respPa    <= hitFound ? {pfnQ[hitIdx], lookupVa[OFFS_W-1:0]} : '0;
      end else begin
        respFault <= 1'b0;
        respPa    <= '0;
      end
    end
  end

  // R6: the chosen entry is the lowest matching one
  p_lowest_match_r6: assert property (@(posedge clk) disable iff (!rstN)
    hitFound |-> (grantVec[hitIdx] && $onehot0(grantVec)));
  // R2: a lookup is answered in the next cycle
  p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.lookupCap |=> respValid);
  // R8: no response and no fault without a lookup
  p_no_resp_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.lookupCap |=> (!respValid && !respFault && respPa == '0));
  // R4: a fault carries no address
  p_fault_zero_pa_r4: assert property (@(posedge clk) disable iff (!rstN)
    respFault |-> (respValid && respPa == '0));
  // R3: a hit keeps the page offset unchanged
  p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lookupCap && hitFound) |=> (respPa[OFFS_W-1:0] == $past(lookupVa[OFFS_W-1:0])));
endmodule

// File: rtl/xlate_buf.sv
`timescale 1ns/1ps
module xlate_buf
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lookupEn,
  input  logic [31:0] lookupVa,
  input  logic        fillEn,
  input  logic [19:0] fillVpn,
  input  logic [19:0] fillPfn,
  output logic        respValid,
  output logic        respFault,
  output logic [31:0] respPa
);
  localparam int IDX_W = $clog2(ENTRIES);

  xlateStrb_t       strb;
  logic [IDX_W-1:0] wrIdx;

  xlate_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .lookupEn(lookupEn), .fillEn(fillEn),
    .strb(strb), .wrIdx(wrIdx)
  );

  xlate_dpath #(.ENTRIES(ENTRIES)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx),
    .fillVpn(fillVpn), .fillPfn(fillPfn), .lookupVa(lookupVa),
    .respValid(respValid), .respFault(respFault), .respPa(respPa)
  );
endmodule

// File: tb/xlate_buf_tb.sv
`timescale 1ns/1ps
module xlate_buf_tb;
  localparam int N = 64;
  localparam int NVEC = 8;
  localparam logic [31:0] VA_TAB [NVEC] = '{
    32'h0001_0ABC, 32'h0001_7FFF, 32'h0001_8000, 32'h0000_0123,
    32'h0001_3000, 32'hFFFF_FFFF, 32'h0001_1001, 32'h0002_0555
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupEn = 1'b0, fillEn = 1'b0;
  logic [31:0] lookupVa = '0;
  logic [19:0] fillVpn = '0, fillPfn = '0;
  logic respValid, respFault;
  logic [31:0] respPa;

  int checks = 0, fails = 0;
  bit mValid [N];
  logic [19:0] mVpn [N];
  logic [19:0] mPfn [N];
  int mPtr = 0;

  always #4 clk = ~clk;

  xlate_buf #(.ENTRIES(N)) u_dut (
    .clk(clk), .rstN(rstN), .lookupEn(lookupEn), .lookupVa(lookupVa),
    .fillEn(fillEn), .fillVpn(fillVpn), .fillPfn(fillPfn),
    .respValid(respValid), .respFault(respFault), .respPa(respPa)
  );

  function automatic logic [32:0] modelLook(input logic [31:0] va);
    for (int i = 0; i < N; i++)
      if (mValid[i] && mVpn[i] == va[31:12]) return {1'b0, mPfn[i], va[11:0]};
    return {1'b1, 32'h0};
  endfunction

  task automatic checkResp(input logic eV, input logic eF, input logic [31:0] eP, input string tag);
    checks++;
    if (respValid !== eV || respFault !== eF || respPa !== eP) begin
      fails++;
      $display("FAIL %s: got valid=%0b fault=%0b pa=%h, expected valid=%0b fault=%0b pa=%h",
               tag, respValid, respFault, respPa, eV, eF, eP);
    end
  endtask

  // one cycle: drive at falling edge, update model at rising edge, check at next falling edge
  task automatic step(input logic le, input logic [31:0] va, input logic fe,
                      input logic [19:0] vpn, input logic [19:0] pfn, input string tag);
    logic [32:0] exp;
    lookupEn = le; lookupVa = va; fillEn = fe; fillVpn = vpn; fillPfn = pfn;
    exp = modelLook(va);
    @(posedge clk);
    if (fe) begin
      mValid[mPtr] = 1'b1; mVpn[mPtr] = vpn; mPfn[mPtr] = pfn;
      mPtr = (mPtr + 1) % N;
    end
    @(negedge clk);
    lookupEn = 1'b0; fillEn = 1'b0;
    if (le) checkResp(1'b1, exp[32], exp[31:0], tag);
    else if (tag != "") checkResp(1'b0, 1'b0, 32'h0, tag);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    for (int i = 0; i < N; i++) mValid[i] = 1'b0;
    mPtr = 0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    doReset();
    checkResp(1'b0, 1'b0, 32'h0, "R1 reset outputs");
    step(1'b1, 32'h0000_0000, 1'b0, '0, '0, "R1 empty table faults");
    step(1'b0, 32'h0, 1'b0, '0, '0, "R8 idle after lookup");
    step(1'b0, 32'h0, 1'b0, '0, '0, "R2 no request no response");

    // eight entries, page 0x10+i -> frame 0x80000+i*0x111
    for (int i = 0; i < 8; i++)
      step(1'b0, 32'h0, 1'b1, 20'h10 + 20'(i), 20'h80000 + 20'(i * 'h111), "");
    // table walk: hits use R3, misses use R4
    for (int v = 0; v < NVEC; v++) begin
      logic [32:0] e;
      e = modelLook(VA_TAB[v]);
      step(1'b1, VA_TAB[v], 1'b0, '0, '0, e[32] ? "R4 miss vector" : "R3 hit vector");
    end

    // duplicate page 0x10 in slot 8; slot 0 must still win
    step(1'b0, 32'h0, 1'b1, 20'h10, 20'hABCDE, "");
    step(1'b1, 32'h0001_0777, 1'b0, '0, '0, "R6 lowest index wins");

    // same-cycle refill and lookup of page 0x55
    step(1'b1, 32'h0005_5010, 1'b1, 20'h55, 20'h12345, "R7 lookup sees old table");
    step(1'b1, 32'h0005_5010, 1'b0, '0, '0, "R7 refill visible next cycle");

    // complete the lap: the pointer is at 10, fill up to slot N-1
    for (int k = 10; k < N; k++)
      step(1'b0, 32'h0, 1'b1, 20'h200 + 20'(k), 20'h40000 + 20'(k), "");
    step(1'b1, 32'h0020_0FFF + (32'(N - 1) << 12), 1'b0, '0, '0, "R5 last slot filled");
    // wrap: this refill replaces slot 0 (page 0x10)
    step(1'b0, 32'h0, 1'b1, 20'h999, 20'h77777, "");
    step(1'b1, 32'h0099_9ABC, 1'b0, '0, '0, "R5 wrapped refill hits");
    step(1'b1, 32'h0001_0002, 1'b0, '0, '0, "R5 slot 0 replaced, slot 8 now answers");
    step(1'b1, 32'h0001_1002, 1'b0, '0, '0, "R5 slot 1 untouched");

    // reset mid-run clears everything
    doReset();
    checkResp(1'b0, 1'b0, 32'h0, "R1 reset mid-run outputs");
    step(1'b1, 32'h0099_9ABC, 1'b0, '0, '0, "R1 reset clears valid");
    step(1'b0, 32'h0, 1'b1, 20'h999, 20'h00001, "");
    step(1'b1, 32'h0099_9ABC, 1'b0, '0, '0, "R5 pointer restarts at slot 0");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule